// File: doc/BRIEF.md
# Buck Rail Gate Sequencer with Pulse Skipping

This block is the digital decision layer of one synchronous buck rail. It takes the oscillator's cycle-start pulse, the trip of the peak-current comparator and a set of status comparators. From them it produces the two gate enables for the upper and lower switches. Dead time is adaptive in both directions: the upper switch waits for the lower gate to be seen low, and the lower switch waits for the switch node to fall. If the switch-node flag never arrives, a short tick timeout enables the lower switch anyway. Overcurrent in either direction ends the affected switch's conduction for the rest of the cycle. A fault input overrides everything and parks the stage with the lower switch on.

Light load is handled by a pulse-skipping mode. On entry the block raises a target-offset output, which moves the regulation point up a little, and lets the entry cycle fire as one extra pulse. After that, cycle starts are ignored while feedback stays above the reference. In this mode the lower switch also turns off at the inductor current zero crossing. A sag flag from the auxiliary rail pulls the block out of this mode and holds it in continuous conduction for a parameterised number of cycles (eight by default). A disable pin forces fixed-frequency continuous conduction at all times.

Top module: `buck_gate_logic`

## Requirements
- R1: While reset is high and in the cycle after it, hs_en, ls_en and tgt_raise are all 0.
- R2: A non-skipped cyc_start ends any conduction and starts a new cycle. hs_en goes to 1 once lg_low is seen high, and goes back to 0 on pwm_trip.
- R3: hs_en never rises unless lg_low was 1 at the edge that enables it. hs_en and ls_en are never 1 together.
- R4: After the upper switch turns off, ls_en goes to 1 on the edge where sw_low is seen. It then stays 1 until the next non-skipped cyc_start.
- R5: If sw_low never comes, ls_en goes to 1 after TMO_TICKS clocks in the wait state (4 by default) and not earlier.
- R6: oc_pos turns hs_en off on the next edge, and hs_en stays 0 for the rest of that cycle.
- R7: oc_neg turns ls_en off on the next edge, and ls_en stays 0 until the next cycle start, even if sw_low is high.
- R8: zero_x turns ls_en off only when skip_dis is 0 and no forced burst is active. With skip_dis at 1, zero_x has no effect.
- R9: At a cyc_start with skip_dis 0, light_load 1 and no burst pending, the block enters pulse skipping. tgt_raise goes to 1 and that cycle still produces a high-side pulse.
- R10: While pulse skipping, a cyc_start with fb_below 0 is ignored and a cyc_start with fb_below 1 starts a cycle. A cyc_start with light_load 0 leaves the mode: tgt_raise drops and the cycle fires.
- R11: skip_dis at 1 clears pulse skipping on the next edge (tgt_raise 0), and from then on every cyc_start fires.
- R12: aux_low clears pulse skipping at once. The current cycle and the next BURST_CYC cycle starts then run in continuous conduction: no skipping, no skip entry, and zero_x ignored. Entry is allowed again at the following cycle start.
- R13: While fault_lsd is 1, hs_en is 0 and ls_en is 1 in the same cycle. After it drops, the lower switch stays on until the next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse at each oscillator cycle start |
| pwm_trip | input | 1 | Peak-current comparator trip |
| sw_low | input | 1 | Switch node below its low threshold |
| lg_low | input | 1 | Lower gate voltage confirmed low |
| oc_pos | input | 1 | Positive overcurrent |
| oc_neg | input | 1 | Negative overcurrent |
| zero_x | input | 1 | Inductor current about to reverse |
| fb_below | input | 1 | Feedback below the (raised) reference |
| light_load | input | 1 | Current below a quarter of peak |
| skip_dis | input | 1 | 1 = fixed-frequency continuous conduction only |
| aux_low | input | 1 | Auxiliary rail sag, requests forced burst |
| fault_lsd | input | 1 | Fault override: upper off, lower on |
| hs_en | output | 1 | Upper switch gate enable |
| ls_en | output | 1 | Lower switch gate enable |
| tgt_raise | output | 1 | Regulation target offset request |

## Verification
Two collisions are staged on purpose. In the first, zero_x is raised while the lower switch conducts during a forced burst. The bench judges that ls_en stays 1, because the burst must beat diode emulation. In the second, fault_lsd is raised while hs_en is high. The sample taken one clock later must show the upper switch off and the lower on in the same cycle, and it must still show the lower switch on after the fault drops. A further case lets the last burst cycle start and the skip re-entry decision meet at neighbouring cycle starts, and the bench checks that re-entry happens exactly one cycle start after the burst ends.

// File: rtl/buckgl_pkg.sv
package buckgl_pkg;

    typedef enum logic [2:0] {
        GS_OFF     = 3'd0,
        GS_WAIT_LG = 3'd1,
        GS_HS      = 3'd2,
        GS_WAIT_SW = 3'd3,
        GS_LS      = 3'd4
    } gate_st_e;

    typedef struct packed {
        logic sw_low;
        logic lg_low;
        logic oc_pos;
        logic oc_neg;
        logic zero_x;
    } stage_flags_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_drv_t;

    function automatic gate_drv_t drive_of(gate_st_e st, logic force_ls);
        gate_drv_t d;
        d.hs = (st == GS_HS) && !force_ls;
        d.ls = (st == GS_LS) || force_ls;
        return d;
    endfunction

endpackage

// File: rtl/buckgl_skip.sv
module buckgl_skip
    import buckgl_pkg::*;
#(
    parameter int BURST_CYC   = 8,
    parameter bit AUX_FORCE_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic fb_below,
    input  logic light_load,
    input  logic skip_dis,
    input  logic aux_low,
    output logic skip_now,
    output logic dem_ok,
    output logic tgt_raise
);
    localparam int BW = $clog2(BURST_CYC + 1);

    logic          skip_mode;
    logic [BW-1:0] burst_cnt;
    logic          cyc_forced;
    logic          aux_req;

    generate
        if (AUX_FORCE_EN) begin : g_burst
            assign aux_req = aux_low;
            always_ff @(posedge clk) begin
                if (rst) begin
                    burst_cnt  <= '0;
                    cyc_forced <= 1'b0;
                end else if (aux_low) begin
                    burst_cnt  <= BW'(BURST_CYC);
                    cyc_forced <= 1'b1;
                end else if (cyc_start) begin
                    cyc_forced <= (burst_cnt != '0);
                    if (burst_cnt != '0)
                        burst_cnt <= burst_cnt - 1'b1;
                end
            end
        end else begin : g_noburst
            assign aux_req    = 1'b0;
            assign burst_cnt  = '0;
            assign cyc_forced = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            skip_mode <= 1'b0;
        else if (skip_dis || aux_req)
            skip_mode <= 1'b0;
        else if (cyc_start) begin
            if (skip_mode)
                skip_mode <= light_load;
            else
                skip_mode <= light_load && (burst_cnt == '0);
        end
    end

    assign skip_now  = cyc_start && skip_mode && light_load && !fb_below
                       && !skip_dis && !aux_req;
    assign dem_ok    = !skip_dis && !cyc_forced;
    assign tgt_raise = skip_mode;

    // R11
    dis_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(skip_dis) |-> !tgt_raise);
    // R12
    aux_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(aux_req) |-> !tgt_raise);
    // R12
    burst_range_chk: assert property (@(posedge clk) disable iff (rst)
        burst_cnt <= BW'(BURST_CYC));

endmodule

// File: rtl/buckgl_fsm.sv
module buckgl_fsm
    import buckgl_pkg::*;
#(
    parameter int TMO_TICKS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cyc_start,
    input  logic         skip_now,
    input  logic         pwm_trip,
    input  stage_flags_t flags,
    input  logic         dem_ok,
    input  logic         fault_lsd,
    output gate_drv_t    drv
);
    localparam int TW = (TMO_TICKS > 2) ? $clog2(TMO_TICKS) : 1;

    gate_st_e      st, nxt;
    logic [TW-1:0] tmo;

    always_comb begin
        nxt = st;
        if (fault_lsd)
            nxt = GS_LS;
        else if (cyc_start && !skip_now)
            nxt = GS_WAIT_LG;
        else begin
            unique case (st)
                GS_WAIT_LG: if (flags.oc_pos)      nxt = GS_WAIT_SW;
                            else if (flags.lg_low) nxt = GS_HS;
                GS_HS:      if (pwm_trip || flags.oc_pos) nxt = GS_WAIT_SW;
                GS_WAIT_SW: if (flags.oc_neg) nxt = GS_OFF;
                            else if (flags.sw_low || tmo == TW'(TMO_TICKS - 1))
                                nxt = GS_LS;
                GS_LS:      if (flags.oc_neg || (flags.zero_x && dem_ok))
                                nxt = GS_OFF;
                default:    nxt = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= GS_OFF;
            tmo <= '0;
        end else begin
            st  <= nxt;
            tmo <= (st == GS_WAIT_SW && nxt == GS_WAIT_SW) ? tmo + 1'b1 : '0;
        end
    end

    assign drv = drive_of(st, fault_lsd);

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(drv.hs && drv.ls));
    // R3
    hs_needs_lg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.hs) |-> $past(flags.lg_low));
    // R6
    oc_pos_cut_chk: assert property (@(posedge clk) disable iff (rst)
        $past(flags.oc_pos) |-> !drv.hs);
    // R7
    oc_neg_cut_chk: assert property (@(posedge clk) disable iff (rst)
        $past(flags.oc_neg) && !$past(fault_lsd) && !fault_lsd |-> !drv.ls);
    // R13
    fault_park_chk: assert property (@(posedge clk) disable iff (rst)
        fault_lsd |-> (!drv.hs && drv.ls));

endmodule

// File: rtl/buck_gate_logic.sv
module buck_gate_logic
    import buckgl_pkg::*;
#(
    parameter int TMO_TICKS    = 4,
    parameter int BURST_CYC    = 8,
    parameter bit AUX_FORCE_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic pwm_trip,
    input  logic sw_low,
    input  logic lg_low,
    input  logic oc_pos,
    input  logic oc_neg,
    input  logic zero_x,
    input  logic fb_below,
    input  logic light_load,
    input  logic skip_dis,
    input  logic aux_low,
    input  logic fault_lsd,
    output logic hs_en,
    output logic ls_en,
    output logic tgt_raise
);
    stage_flags_t flags;
    gate_drv_t    drv;
    logic         skip_now;
    logic         dem_ok;

    assign flags = '{sw_low: sw_low, lg_low: lg_low, oc_pos: oc_pos,
                     oc_neg: oc_neg, zero_x: zero_x};

    buckgl_skip #(
        .BURST_CYC   (BURST_CYC),
        .AUX_FORCE_EN(AUX_FORCE_EN)
    ) u_skip (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .fb_below  (fb_below),
        .light_load(light_load),
        .skip_dis  (skip_dis),
        .aux_low   (aux_low),
        .skip_now  (skip_now),
        .dem_ok    (dem_ok),
        .tgt_raise (tgt_raise)
    );

    buckgl_fsm #(
        .TMO_TICKS(TMO_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cyc_start(cyc_start),
        .skip_now (skip_now),
        .pwm_trip (pwm_trip),
        .flags    (flags),
        .dem_ok   (dem_ok),
        .fault_lsd(fault_lsd),
        .drv      (drv)
    );

    assign hs_en = drv.hs;
    assign ls_en = drv.ls;

endmodule

// File: tb/tb_buck_gate_logic.sv
module tb_buck_gate_logic;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_start = 0, pwm_trip = 0, sw_low = 0, lg_low = 1;
    logic oc_pos = 0, oc_neg = 0, zero_x = 0, fb_below = 0;
    logic light_load = 0, skip_dis = 1, aux_low = 0, fault_lsd = 0;
    logic hs_en, ls_en, tgt_raise;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int    hs;
        int    ls;
        int    b;
        string rq;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    buck_gate_logic dut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .pwm_trip(pwm_trip),
        .sw_low(sw_low), .lg_low(lg_low), .oc_pos(oc_pos), .oc_neg(oc_neg),
        .zero_x(zero_x), .fb_below(fb_below), .light_load(light_load),
        .skip_dis(skip_dis), .aux_low(aux_low), .fault_lsd(fault_lsd),
        .hs_en(hs_en), .ls_en(ls_en), .tgt_raise(tgt_raise)
    );

    // expected values after the coming edge; -1 means not checked
    task automatic chk(input int hs, input int ls, input int b, input string rq);
        exp_t e;
        e.hs = hs; e.ls = ls; e.b = b; e.rq = rq;
        sb_q.push_back(e);
        @(negedge clk);
        cyc_start = 0; pwm_trip = 0; oc_pos = 0; oc_neg = 0;
        zero_x = 0; aux_low = 0;
    endtask

    task automatic cmp1(input string rq, input string nm, input int act, input int exp);
        if (exp >= 0) begin
            checks++;
            if (act != exp) begin
                errors++;
                $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, nm, act, exp, $time);
            end
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                cmp1(e.rq, "hs_en", int'(hs_en), e.hs);
                cmp1(e.rq, "ls_en", int'(ls_en), e.ls);
                cmp1(e.rq, "tgt_raise", int'(tgt_raise), e.b);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1;
        chk(0, 0, 0, "R1");
        rst = 0;
        chk(0, 0, 0, "R1");

        // continuous conduction, fixed frequency
        cyc_start = 1; lg_low = 0; chk(0, 0, 0, "R3");
        chk(0, 0, 0, "R3");
        lg_low = 1; chk(1, 0, 0, "R2");
        chk(1, 0, 0, "R2");
        pwm_trip = 1; chk(0, 0, 0, "R2");
        chk(0, 0, 0, "R4");
        sw_low = 1; chk(0, 1, 0, "R4");
        sw_low = 0; zero_x = 1; chk(0, 1, 0, "R8");
        chk(0, 1, 0, "R4");
        cyc_start = 1; lg_low = 0; chk(0, 0, 0, "R4");
        lg_low = 1; chk(1, 0, 0, "R2");
        pwm_trip = 1; chk(0, 0, 0, "R2");
        chk(0, 0, 0, "R5");
        chk(0, 0, 0, "R5");
        chk(0, 0, 0, "R5");
        chk(0, 1, 0, "R5");
        oc_neg = 1; chk(0, 0, 0, "R7");
        sw_low = 1; chk(0, 0, 0, "R7");
        sw_low = 0;
        cyc_start = 1; chk(0, 0, 0, "R2");
        chk(1, 0, 0, "R2");
        oc_pos = 1; chk(0, 0, 0, "R6");
        sw_low = 1; chk(0, 1, 0, "R6");
        sw_low = 0;

        // fault override
        fault_lsd = 1; chk(0, 1, 0, "R13");
        cyc_start = 1; chk(0, 1, 0, "R13");
        fault_lsd = 0; cyc_start = 1; chk(0, 0, 0, "R2");
        chk(1, 0, 0, "R2");
        fault_lsd = 1; chk(0, 1, 0, "R13");
        fault_lsd = 0; chk(0, 1, 0, "R13");

        // pulse skipping
        skip_dis = 0; light_load = 1; fb_below = 0;
        cyc_start = 1; chk(0, 0, 1, "R9");
        chk(1, 0, 1, "R9");
        pwm_trip = 1; chk(0, 0, 1, "R9");
        sw_low = 1; chk(0, 1, 1, "R4");
        sw_low = 0; zero_x = 1; chk(0, 0, 1, "R8");
        cyc_start = 1; chk(0, 0, 1, "R10");
        chk(0, 0, 1, "R10");
        cyc_start = 1; fb_below = 1; chk(0, 0, 1, "R10");
        fb_below = 0; chk(1, 0, 1, "R10");
        pwm_trip = 1; chk(0, 0, 1, "R10");

        // auxiliary sag: forced burst
        aux_low = 1; chk(0, 0, 0, "R12");
        sw_low = 1; chk(0, 1, 0, "R12");
        sw_low = 0; zero_x = 1; chk(0, 1, 0, "R12");
        cyc_start = 1; chk(0, 0, 0, "R12");
        chk(1, 0, 0, "R12");
        for (int i = 2; i <= 8; i++) begin
            cyc_start = 1; chk(0, 0, 0, "R12");
            chk(1, 0, 0, "R12");
        end
        cyc_start = 1; chk(0, 0, 1, "R12");
        chk(1, 0, 1, "R9");
        pwm_trip = 1; chk(0, 0, 1, "R9");
        cyc_start = 1; chk(0, -1, 1, "R10");
        chk(0, -1, 1, "R10");

        // disable pin clears the mode
        skip_dis = 1; chk(0, -1, 0, "R11");
        cyc_start = 1; chk(0, 0, 0, "R11");
        chk(1, 0, 0, "R11");
        pwm_trip = 1; chk(0, 0, 0, "R11");

        // exit on heavier load
        skip_dis = 0; cyc_start = 1; chk(0, 0, 1, "R9");
        chk(1, 0, 1, "R9");
        pwm_trip = 1; chk(0, 0, 1, "R9");
        light_load = 0; cyc_start = 1; chk(0, 0, 0, "R10");
        chk(1, 0, 0, "R10");

        chk(-1, -1, -1, "end");
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule